// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Cell

One of these cells sits in each slot of a shared parallel backplane and decides whether its module may become bus master. Priority comes only from position in a grant chain. The highest slot takes the shared request line as its grant input. Each cell hands the grant on to the next lower slot unless its own module wants the bus. At the bottom of the chain, the board ties the last grant output back to the shared busy line.

The cell drives the shared request line while its module wants the bus and no master is seen. When a new grant edge arrives, the cell samples the module's request once. If the module is asking, the cell drives busy and reports mastership to the module. If not, it asserts grant-out for as long as grant-in stays high. The module ends mastership with a done level. The cell does not let go of busy while a data strobe or an acknowledge is still seen on the backplane.

Every shared-line input passes through a two-stage synchroniser. Every output is an open-drain drive enable. A bus reset, taken from the backplane, returns the cell to idle. A parameter turns the cell into a plain pass-through for slots that can never be masters.

Top module: `chain_arb_cell`

## Requirements
- R1: Shared-line inputs reach the decision logic through two flops. A rising grant-in is acted on at the third rising clock edge after it is applied, and not earlier.
- R2: `req_drive_o` is high in the cycle after an edge at which `local_req_i` was high, the synchronised busy line was low and the cell was idle. It is low in every other cycle.
- R3: At a rising edge of the synchronised grant, seen while the synchronised request line is high and the cell is idle, the cell samples `local_req_i`. If it is 1, `busy_drive_o` and `master_o` go high together.
- R4: If the sampled request is 0, `grant_o` goes high instead. `grant_o` and `busy_drive_o` are never high together.
- R5: A cell that is passing the grant drops `grant_o` at the third edge after grant-in falls.
- R6: Mastership ends at the third edge after `local_done_i` is high while strobe and acknowledge have both been low at the inputs. While either is still seen, busy stays asserted.
- R7: A grant-in that stays high after mastership ends does not start a new round, even with `local_req_i` high. Only a fresh low-to-high grant edge starts one.
- R8: At the third edge after `bus_reset_i` is applied, `req_drive_o`, `grant_o`, `busy_drive_o` and `master_o` are all low.
- R9: With `MASTER_CAPABLE` = 0, `grant_o` equals `grant_i` with no delay, and the other three outputs stay low.
- R10: After `rst_ni` is released with all inputs low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | Backplane reset line, asynchronous to the cell clock |
| local_req_i | input | 1 | Module wants bus mastership |
| local_done_i | input | 1 | Module has finished all of its transactions |
| busy_i | input | 1 | Resolved shared busy line |
| req_line_i | input | 1 | Resolved shared request line |
| grant_i | input | 1 | Grant from the higher-priority neighbour |
| strobe_i | input | 1 | Resolved data strobe |
| ack_i | input | 1 | Resolved data-done acknowledge |
| req_drive_o | output | 1 | Drive enable for the shared request line |
| busy_drive_o | output | 1 | Drive enable for the shared busy line |
| grant_o | output | 1 | Grant to the next lower-priority slot |
| master_o | output | 1 | Mastership held, to the local module |

## Verification
The assertions assume the synchronised inputs behave as the backplane protocol promises. In particular, a module only asks for the bus with a request that it keeps stable over the grant edge. The checks on release and request blocking rely on nothing else about the inputs. The stimulus holds each input for several cycles and changes it with low probability, so grant edges, strobe and acknowledge windows and done levels overlap in many orders. It asserts bus reset only rarely. Directed phases fix the exact edge counts for grant latency, release under strobe, grant-held-after-release and bus reset.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;

  localparam int unsigned IX_BUSY  = 0;
  localparam int unsigned IX_REQ   = 1;
  localparam int unsigned IX_GNT   = 2;
  localparam int unsigned IX_STB   = 3;
  localparam int unsigned IX_ACK   = 4;
  localparam int unsigned IX_RST   = 5;
  localparam int unsigned N_SHARED = 6;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import chain_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_busy_i,
  input  logic s_req_i,
  input  logic s_grant_i,
  input  logic s_strobe_i,
  input  logic s_ack_i,
  input  logic s_rst_i,
  input  logic local_req_i,
  input  logic local_done_i,
  output logic req_drive_o,
  output logic busy_drive_o,
  output logic grant_o,
  output logic master_o
);
  arb_state_e state_q, state_d;
  logic       gnt_prev_q;
  logic       req_q;
  logic       gnt_edge;
  logic       xfer_active;

  assign gnt_edge    = s_grant_i & ~gnt_prev_q & s_req_i;
  assign xfer_active = s_strobe_i | s_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (gnt_edge) state_d = local_req_i ? ST_OWN : ST_PASS;
      ST_PASS: if (!s_grant_i) state_d = ST_IDLE;
      ST_OWN:  if (local_done_i && !xfer_active) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (s_rst_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      gnt_prev_q <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      gnt_prev_q <= s_grant_i;
      req_q      <= ~s_rst_i & local_req_i & ~s_busy_i & (state_q == ST_IDLE);
    end
  end

  assign req_drive_o  = req_q;
  assign busy_drive_o = (state_q == ST_OWN);
  assign master_o     = (state_q == ST_OWN);
  assign grant_o      = (state_q == ST_PASS);

  p_req_blocked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_busy_i |=> !req_drive_o);

  p_take_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_o) |-> $past(local_req_i) && $past(s_grant_i));

  p_grant_busy_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && busy_drive_o));

  p_release_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_drive_o) |-> $past(s_rst_i) ||
      ($past(local_done_i) && !$past(s_strobe_i) && !$past(s_ack_i)));

  p_bus_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rst_i |=> !busy_drive_o && !grant_o && !req_drive_o);
endmodule

// File: rtl/chain_arb_cell.sv
module chain_arb_cell
  import chain_arb_pkg::*;
#(
  parameter bit          MASTER_CAPABLE = 1'b1,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic local_req_i,
  input  logic local_done_i,
  input  logic busy_i,
  input  logic req_line_i,
  input  logic grant_i,
  input  logic strobe_i,
  input  logic ack_i,
  output logic req_drive_o,
  output logic busy_drive_o,
  output logic grant_o,
  output logic master_o
);
  generate
    if (MASTER_CAPABLE) begin : g_master
      logic [N_SHARED-1:0] raw_in;
      logic [N_SHARED-1:0] sync_in;

      always_comb begin
        raw_in          = '0;
        raw_in[IX_BUSY] = busy_i;
        raw_in[IX_REQ]  = req_line_i;
        raw_in[IX_GNT]  = grant_i;
        raw_in[IX_STB]  = strobe_i;
        raw_in[IX_ACK]  = ack_i;
        raw_in[IX_RST]  = bus_reset_i;
      end

      arb_sync #(.WIDTH(N_SHARED), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_in),
        .q_o    (sync_in)
      );

      arb_grant_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .s_busy_i     (sync_in[IX_BUSY]),
        .s_req_i      (sync_in[IX_REQ]),
        .s_grant_i    (sync_in[IX_GNT]),
        .s_strobe_i   (sync_in[IX_STB]),
        .s_ack_i      (sync_in[IX_ACK]),
        .s_rst_i      (sync_in[IX_RST]),
        .local_req_i  (local_req_i),
        .local_done_i (local_done_i),
        .req_drive_o  (req_drive_o),
        .busy_drive_o (busy_drive_o),
        .grant_o      (grant_o),
        .master_o     (master_o)
      );
    end else begin : g_feed
      // slot that never masters: grant passes straight through
      assign grant_o      = grant_i;
      assign req_drive_o  = 1'b0;
      assign busy_drive_o = 1'b0;
      assign master_o     = 1'b0;
    end
  endgenerate
endmodule

// File: tb/sim_chain_arb_cell.sv
module sim_chain_arb_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 0, lreq = 0, ldone = 0, busy = 0, rqln = 0, gnt = 0, stb = 0, ack = 0;
  logic req_o, busy_o, gnt_o, mst_o;
  logic f_req_o, f_busy_o, f_gnt_o, f_mst_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  chain_arb_cell u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .local_req_i(lreq),
    .local_done_i(ldone), .busy_i(busy), .req_line_i(rqln), .grant_i(gnt),
    .strobe_i(stb), .ack_i(ack), .req_drive_o(req_o), .busy_drive_o(busy_o),
    .grant_o(gnt_o), .master_o(mst_o));

  chain_arb_cell #(.MASTER_CAPABLE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .local_req_i(lreq),
    .local_done_i(ldone), .busy_i(busy), .req_line_i(rqln), .grant_i(gnt),
    .strobe_i(stb), .ack_i(ack), .req_drive_o(f_req_o), .busy_drive_o(f_busy_o),
    .grant_o(f_gnt_o), .master_o(f_mst_o));

  // reference model built from the requirements: 2 sync edges, then decide
  logic [5:0] m_s1, m_s2;   // {rst, ack, stb, gnt, rqln, busy}
  logic m_gp, m_req;
  int   m_st;               // 0 idle, 1 pass, 2 own

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_gp <= 0; m_req <= 0; m_st <= 0;
    end else begin
      m_s1 <= {bus_reset, ack, stb, gnt, rqln, busy};
      m_s2 <= m_s1;
      m_gp <= m_s2[2];
      m_req <= !m_s2[5] && lreq && !m_s2[0] && (m_st == 0);
      if (m_s2[5]) m_st <= 0;
      else if (m_st == 0 && m_s2[2] && !m_gp && m_s2[1]) m_st <= lreq ? 2 : 1;
      else if (m_st == 1 && !m_s2[2]) m_st <= 0;
      else if (m_st == 2 && ldone && !m_s2[3] && !m_s2[4]) m_st <= 0;
    end
  end

  function automatic bit exp_busy(int st); return st == 2; endfunction
  function automatic bit exp_gnt(int st);  return st == 1; endfunction

  task automatic check(string tag, logic act, logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #1_600_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R10 req", req_o, 0);  check("R10 busy", busy_o, 0);
    check("R10 gnt", gnt_o, 0);  check("R10 mst", mst_o, 0);

    lreq = 1; tick(1);
    check("R2 req idle", req_o, 1);
    busy = 1; tick(2);
    check("R2 req before busy seen", req_o, 1);
    tick(1);
    check("R2 req blocked by busy", req_o, 0);
    busy = 0; tick(3);
    check("R2 req after busy low", req_o, 1);

    rqln = 1; gnt = 1; tick(2);
    check("R1 no take after 2 edges", busy_o, 0);
    tick(1);
    check("R1 R3 take at 3rd edge", busy_o, 1);
    check("R3 master", mst_o, 1);

    stb = 1; tick(3);
    ldone = 1; tick(4);
    check("R6 held under strobe", busy_o, 1);
    stb = 0; ack = 1; tick(4);
    check("R6 held under ack", busy_o, 1);
    ack = 0; tick(2);
    check("R6 held while ack in sync", busy_o, 1);
    tick(1);
    check("R6 released", busy_o, 0);
    check("R6 master off", mst_o, 0);

    ldone = 0; tick(6);
    check("R7 no retake on held grant", busy_o, 0);
    check("R7 no pass on held grant", gnt_o, 0);

    lreq = 0; gnt = 0; tick(4);
    gnt = 1; tick(3);
    check("R4 pass grant", gnt_o, 1);
    check("R4 not busy", busy_o, 0);
    gnt = 0; tick(2);
    check("R5 grant held 2 edges", gnt_o, 1);
    tick(1);
    check("R5 grant dropped", gnt_o, 0);

    lreq = 1; tick(2); gnt = 1; tick(3);
    check("R8 pre master", mst_o, 1);
    bus_reset = 1; tick(2);
    check("R8 before reset seen", mst_o, 1);
    tick(1);
    check("R8 busy", busy_o, 0); check("R8 gnt", gnt_o, 0); check("R8 req", req_o, 0);
    bus_reset = 0; gnt = 0; lreq = 0; tick(4);

    for (int i = 0; i < 4000; i++) begin
      check("R2 model req", req_o, m_req);
      check("R4 model gnt", gnt_o, exp_gnt(m_st));
      check("R6 model busy", busy_o, exp_busy(m_st));
      check("R3 model mst", mst_o, exp_busy(m_st));
      check("R9 feed gnt", f_gnt_o, gnt);
      check("R9 feed others", f_req_o | f_busy_o | f_mst_o, 0);
      if ($urandom_range(7) == 0) lreq  = ~lreq;
      if ($urandom_range(9) == 0) ldone = ~ldone;
      if ($urandom_range(11) == 0) busy = ~busy;
      if ($urandom_range(9) == 0) rqln  = ~rqln;
      if ($urandom_range(7) == 0) gnt   = ~gnt;
      if ($urandom_range(5) == 0) stb   = ~stb;
      if ($urandom_range(5) == 0) ack   = ~ack;
      bus_reset = ($urandom_range(127) == 0);
      tick(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule